// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block drives the parallel programming port of a small on-chip flash array. An external programmer presents an address, a data byte and a two-bit operation code, raises the high-voltage-present flag and pulses a program strobe. The sequencer then runs one of three timed operations: a byte write, a whole-array erase, or a lock-bit write. While it runs, a ready flag is held low. An internal cycle counter stands in for the physical programming delay.

The flash cells are modelled as a register array. Erased bytes read 0xFF, and a byte write can only clear bits. While a byte write runs, reading the target location returns data-polling status: the inverse of bit 7 of the byte being written. Two lock bits block verification reads once either of them is set. The lock bits cannot be read back through the data path, and only an erase clears them.

Top module: `flash_prog_seq`

## Requirements
- R1: An operation starts only on a rising edge of `strobe_i`, sampled at a clock edge, while `hv_i` is high, `ready_o` is high and `mode_i` is not 2'b00. If `hv_i` is low, the strobe has no effect: `ready_o` stays high and the array keeps its content.
- R2: After a start, `ready_o` goes low from the next cycle. It stays low for exactly WRITE_CYCLES cycles for a byte write (`mode_i`=2'b01) or a lock write (`mode_i`=2'b11), and for exactly ERASE_CYCLES cycles for an erase (`mode_i`=2'b10).
- R3: During a byte write, a read of the target address returns {~D[7], 7'b0000000}, where D is the byte being written. Reads of other addresses return normal data.
- R4: When a byte write completes, the target location holds the old value ANDed with the written byte, and this value appears on all eight bits of `rdata_o`.
- R5: A strobe that arrives while `ready_o` is low is ignored. It neither extends the busy period nor programs the address and data presented with it.
- R6: An erase sets every byte to 0xFF and clears both lock bits. While the erase runs, a read of any address returns 8'h00.
- R7: A lock write sets lock bit 1 when `wdata_i[0]`=1 and lock bit 2 when `wdata_i[1]`=1. While either lock bit is set and the block is idle, every read returns 0xFF.
- R8: After reset, `ready_o` is high, every byte reads 0xFF and both lock bits are clear.
- R9: In read mode (`mode_i`=2'b00), a strobe never starts an operation. `rdata_o` shows the byte at `addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Program and read address |
| wdata_i | input | 8 | Byte to program; bits 1:0 select the lock bits in lock mode |
| mode_i | input | 2 | 00 read, 01 byte write, 10 erase, 11 lock write |
| hv_i | input | 1 | High-voltage-present flag |
| strobe_i | input | 1 | Program strobe; its rising edge launches an operation |
| rdata_o | output | 8 | Read data or polling status |
| ready_o | output | 1 | High when idle, low while an operation runs |

## Verification
The bench builds the block with ADDR_W=4, WRITE_CYCLES=12 and ERASE_CYCLES=20. With these values, every busy period can be counted cycle by cycle, and a second strobe can be placed in the middle of a write. The small array also lets the erase be checked at addresses across the whole range, and lets a polling read at the target be compared against a read elsewhere while the write is in progress. The lock and erase sequences run back to back, so the bench shows that an erase lifts the lock.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_BYTE  = 2'b01,
    OP_ERASE = 2'b10,
    OP_LOCK  = 2'b11
  } flash_op_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 1500,
  parameter int ERASE_CYCLES = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              hv_i,
  input  flash_op_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              busy_o,
  output flash_op_e         op_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [7:0]        pend_data_o,
  output logic              commit_o
);
  localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic              strobe_q;
  logic              busy_q;
  flash_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              launch;
  logic              done;

  assign launch = strobe_i && !strobe_q && hv_i && !busy_q && (mode_i != OP_READ);
  assign done   = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
      op_q     <= OP_READ;
      addr_q   <= '0;
      data_q   <= '0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (launch) begin
        busy_q <= 1'b1;
        op_q   <= mode_i;
        addr_q <= addr_i;
        data_q <= wdata_i;
        cnt_q  <= (mode_i == OP_ERASE) ? ER_LOAD : WR_LOAD;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign op_o        = op_q;
  assign pend_addr_o = addr_q;
  assign pend_data_o = data_q;
  assign commit_o    = done;
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  flash_op_e         op_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_byte_o,
  output logic [1:0]        lock_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];
  logic [1:0] lock_q;
  logic       erase_hit;

  assign erase_hit = commit_i && (op_i == OP_ERASE);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic byte_hit;
    assign byte_hit = commit_i && (op_i == OP_BYTE) && (wr_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cell_q[i] <= BLANK_BYTE;
      else if (erase_hit) cell_q[i] <= BLANK_BYTE;
      else if (byte_hit)  cell_q[i] <= cell_q[i] & wr_data_i; // cells only discharge
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              lock_q <= 2'b00;
    else if (erase_hit)                       lock_q <= 2'b00;
    else if (commit_i && (op_i == OP_LOCK))   lock_q <= lock_q | wr_data_i[1:0];
  end

  assign rd_byte_o = cell_q[rd_addr_i];
  assign lock_o    = lock_q;
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busy_i,
  input  flash_op_e         op_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic [7:0]        pend_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        cell_i,
  input  logic [1:0]        lock_i,
  output logic [7:0]        rdata_o
);
  logic poll_byte;
  logic poll_erase;
  logic poll_bit;

  assign poll_byte  = busy_i && (op_i == OP_BYTE) && (rd_addr_i == pend_addr_i);
  assign poll_erase = busy_i && (op_i == OP_ERASE);
  // erase target is blank, so its bit 7 is 1
  assign poll_bit   = poll_erase ? 1'b0 : ~pend_data_i[7];

  always_comb begin
    if (poll_byte || poll_erase) rdata_o = {poll_bit, 7'b0};
    else if (|lock_i)            rdata_o = BLANK_BYTE;
    else                         rdata_o = cell_i;
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 1500,
  parameter int ERASE_CYCLES = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        mode_i,
  input  logic              hv_i,
  input  logic              strobe_i,
  output logic [7:0]        rdata_o,
  output logic              ready_o
);
  logic              busy_w;
  flash_op_e         op_w;
  logic [ADDR_W-1:0] pend_addr_w;
  logic [7:0]        pend_data_w;
  logic              commit_w;
  logic [7:0]        cell_w;
  logic [1:0]        lock_w;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) ctrl_i (
    .clk_i, .rst_ni, .strobe_i, .hv_i,
    .mode_i      (flash_op_e'(mode_i)),
    .addr_i, .wdata_i,
    .busy_o      (busy_w),
    .op_o        (op_w),
    .pend_addr_o (pend_addr_w),
    .pend_data_o (pend_data_w),
    .commit_o    (commit_w)
  );

  flash_cell_array #(.ADDR_W(ADDR_W)) array_i (
    .clk_i, .rst_ni,
    .commit_i  (commit_w),
    .op_i      (op_w),
    .wr_addr_i (pend_addr_w),
    .wr_data_i (pend_data_w),
    .rd_addr_i (addr_i),
    .rd_byte_o (cell_w),
    .lock_o    (lock_w)
  );

  flash_read_path #(.ADDR_W(ADDR_W)) rd_i (
    .busy_i      (busy_w),
    .op_i        (op_w),
    .pend_addr_i (pend_addr_w),
    .pend_data_i (pend_data_w),
    .rd_addr_i   (addr_i),
    .cell_i      (cell_w),
    .lock_i      (lock_w),
    .rdata_o
  );

  assign ready_o = ~busy_w;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int WRITE_CYCLES = 1500,
  parameter int ERASE_CYCLES = 4000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       hv_i,
  input logic       strobe_i,
  input logic [7:0] rdata_o,
  input logic       ready_o,
  input logic [1:0] lock_i
);
  localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;

  int run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 0;
    else if (ready_o) run_q <= 0;
    else              run_q <= run_q + 1;
  end

  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && hv_i && $rose(strobe_i) && (mode_i != 2'b00) |=> !ready_o); // R1
  AST_NO_HV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !hv_i |=> ready_o); // R1
  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= MAX_CYC); // R2
  AST_LOCK_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && (lock_i != 2'b00) |-> rdata_o == 8'hFF); // R7
  AST_READ_MODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && (mode_i == 2'b00) |=> ready_o); // R9
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .hv_i(hv_i),
  .strobe_i(strobe_i), .rdata_o(rdata_o), .ready_o(ready_o), .lock_i(lock_w)
);

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int WRC = 12;
  localparam int ERC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [1:0]    mode = 2'b00;
  logic          hv = 1'b0;
  logic          strobe = 1'b0;
  logic [7:0]    rdata;
  logic          ready;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .WRITE_CYCLES(WRC), .ERASE_CYCLES(ERC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .mode_i(mode),
    .hv_i(hv), .strobe_i(strobe), .rdata_o(rdata), .ready_o(ready)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  // strobe rises and falls on negedges; returns at the first negedge after launch
  task automatic launch(input logic [1:0] m, input logic [AW-1:0] a,
                        input logic [7:0] d, input logic h);
    @(negedge clk);
    mode = m; addr = a; wdata = d; hv = h; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; hv = 1'b0; mode = 2'b00;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R8 ready after reset", int'(ready), 1);
    rd(4'd3, v);  chk("R8 blank at 3", v, 8'hFF);
    rd(4'd15, v); chk("R8 blank at 15", v, 8'hFF);
  endtask

  task automatic t_no_hv;
    logic [7:0] v;
    launch(2'b01, 4'd2, 8'h00, 1'b0);
    chk("R1 no hv keeps ready", int'(ready), 1);
    @(negedge clk);
    rd(4'd2, v); chk("R1 no hv keeps data", v, 8'hFF);
  endtask

  task automatic t_read_mode;
    launch(2'b00, 4'd2, 8'h00, 1'b1);
    chk("R9 read-mode strobe keeps ready", int'(ready), 1);
  endtask

  task automatic t_write_poll;
    logic [7:0] v;
    int n;
    launch(2'b01, 4'd2, 8'h35, 1'b1);
    rd(4'd2, v); chk("R3 poll bit7 inverted (0x35)", v, 8'h80);
    rd(4'd5, v); chk("R3 other address normal", v, 8'hFF);
    count_busy(n);
    chk("R2 byte write busy length", n, WRC);
    rd(4'd2, v); chk("R4 true data after write", v, 8'h35);
  endtask

  task automatic t_write_and;
    logic [7:0] v;
    int n;
    launch(2'b01, 4'd2, 8'hF0, 1'b1);
    rd(4'd2, v); chk("R3 poll bit7 inverted (0xF0)", v, 8'h00);
    count_busy(n);
    rd(4'd2, v); chk("R4 write only clears bits", v, 8'h30);
  endtask

  task automatic t_busy_strobe;
    logic [7:0] v;
    int n;
    launch(2'b01, 4'd7, 8'h5A, 1'b1);
    n = 0;
    while (!ready && n < 1000) begin
      if (n == 5) begin
        mode = 2'b01; addr = 4'd8; wdata = 8'h00; hv = 1'b1; strobe = 1'b1;
      end else if (n == 6) begin
        strobe = 1'b0; hv = 1'b0; mode = 2'b00;
      end
      n++;
      @(negedge clk);
    end
    chk("R5 busy not extended", n, WRC);
    rd(4'd8, v); chk("R5 second strobe not programmed", v, 8'hFF);
    rd(4'd7, v); chk("R5 first write intact", v, 8'h5A);
  endtask

  task automatic t_erase;
    logic [7:0] v;
    int n;
    launch(2'b10, 4'd0, 8'h00, 1'b1);
    rd(4'd2, v);  chk("R6 poll during erase", v, 8'h00);
    rd(4'd11, v); chk("R6 poll during erase other addr", v, 8'h00);
    count_busy(n);
    chk("R2 erase busy length", n, ERC);
    rd(4'd2, v);  chk("R6 erased at 2", v, 8'hFF);
    rd(4'd7, v);  chk("R6 erased at 7", v, 8'hFF);
  endtask

  task automatic t_lock;
    logic [7:0] v;
    int n;
    launch(2'b01, 4'd1, 8'h11, 1'b1); count_busy(n);
    rd(4'd1, v); chk("R7 readable before lock", v, 8'h11);
    launch(2'b11, 4'd0, 8'h01, 1'b1); count_busy(n);
    chk("R2 lock write busy length", n, WRC);
    rd(4'd1, v); chk("R7 lock1 blocks read", v, 8'hFF);
    launch(2'b10, 4'd0, 8'h00, 1'b1); count_busy(n);
    launch(2'b01, 4'd1, 8'h22, 1'b1); count_busy(n);
    rd(4'd1, v); chk("R6 erase clears lock", v, 8'h22);
    launch(2'b11, 4'd0, 8'h02, 1'b1); count_busy(n);
    rd(4'd1, v); chk("R7 lock2 blocks read", v, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_hv();
    t_read_mode();
    t_write_poll();
    t_write_and();
    t_busy_strobe();
    t_erase();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule